// File: doc/BRIEF.md
# Row-wise Dark Column Noise Canceller

This block removes row-to-row offset noise from a streaming pixel row. Each row opens with a fixed run of optically black samples. While they stream past, the block keeps a running sum of them and tracks their two smallest and two largest values. When the run is complete, the outliers are taken off the sum and the trimmed sum is scaled down to a per-row reference level.

Every active pixel that follows in the same row has the reference subtracted and a programmable pedestal added. The result is clamped to the pixel range. Dark samples leave the block unchanged and keep their place in the stream, so downstream logic sees the same framing one cycle later.

The correction runs only when two configuration bits are set: the dark-column read enable and the correction enable. With either bit clear, the block forwards pixels unchanged with the same latency. The reference is rebuilt for every row.

Top module: `rownoise_canceller`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `out_line` and `out_pix` are all 0.
- R2: `out_valid` and `out_line` equal `in_valid` and `in_line` one clock earlier, and `out_pix` is 0 on every cycle where `out_valid` is 0.
- R3: A sample with `in_dark`=1 appears on `out_pix` one cycle later with its value unchanged.
- R4: The row reference equals the sum of the row's 36 dark samples, less the two smallest and the two largest, shifted right by 5 bits. The shift yields a 10-bit value.
- R5: When correction is on, an active pixel (`in_valid`=1, `in_line`=1, `in_dark`=0) is output one cycle later as pixel minus reference plus `cfg_pedestal`. The pedestal is read as an unsigned value.
- R6: A corrected result below 0 is output as 0.
- R7: A corrected result above 1023 is output as 1023.
- R8: If `cfg_corr_en`=0 or `cfg_dark_read_en`=0, active pixels pass to the output unchanged, with the same one-cycle latency.
- R9: The dark statistics restart whenever `in_line` is 0. The reference used for a row comes only from that row's own dark samples.
- R10: Duplicated extreme values are trimmed as a multiset: exactly two samples are dropped at each end, even when more than two samples share the extreme value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel strobe |
| in_line | input | 1 | Line-valid framing, high for the duration of a row |
| in_dark | input | 1 | Current sample is an optically black column |
| in_pix | input | 10 | Pixel value |
| cfg_dark_read_en | input | 1 | Dark columns are being read out |
| cfg_corr_en | input | 1 | Row correction requested |
| cfg_pedestal | input | 8 | Positive constant added to corrected pixels |
| out_valid | output | 1 | Output pixel strobe |
| out_line | output | 1 | Output line-valid |
| out_pix | output | 10 | Output pixel value |

## Verification
The assertions assume the following about the input stream:
- Every row delivers its 36 dark samples before its first active pixel.
- `in_line` drops for at least one cycle between rows.
- The configuration does not change within a row.

One assertion flags an active pixel that arrives while correction is on and the dark run is still incomplete.

The stimulus meets these assumptions by building each row from a fixed sequence: 36 dark samples, then active pixels with occasional idle strobes, then two cycles with the line low. The configuration changes only in that gap.

// File: rtl/rnc_pkg.sv
package rnc_pkg;
   // classification of the sample on the input stream
   typedef enum logic [1:0] {
      PK_IDLE   = 2'd0,
      PK_DARK   = 2'd1,
      PK_ACTIVE = 2'd2
   } pix_kind_e;

   function automatic pix_kind_e classify(input logic v, input logic l, input logic d);
      if (!(v && l)) return PK_IDLE;
      if (d)         return PK_DARK;
      return PK_ACTIVE;
   endfunction
endpackage

// File: rtl/rnc_extreme_pair.sv
module rnc_extreme_pair #(
   parameter int W         = 10,
   parameter bit KEEP_HIGH = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] x,
   output logic [W-1:0] e1,
   output logic [W-1:0] e2
);
   localparam logic [W-1:0] INIT = KEEP_HIGH ? {W{1'b0}} : {W{1'b1}};

   logic beats1, beats2;

   generate
      if (KEEP_HIGH) begin : g_high
         assign beats1 = x > e1;
         assign beats2 = x > e2;
         // R10
         hi_order_chk: assert property (@(posedge clk) disable iff (!rst_n) e1 >= e2)
            else $error("largest below second largest");
      end else begin : g_low
         assign beats1 = x < e1;
         assign beats2 = x < e2;
         // R10
         lo_order_chk: assert property (@(posedge clk) disable iff (!rst_n) e1 <= e2)
            else $error("smallest above second smallest");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         e1 <= INIT;
         e2 <= INIT;
      end else if (upd) begin
         if (beats1) begin
            e2 <= e1;
            e1 <= x;
         end else if (beats2) begin
            e2 <= x;
         end
      end
   end
endmodule

// File: rtl/rnc_dark_stats.sv
module rnc_dark_stats #(
   parameter int PIX_W  = 10,
   parameter int DARK_N = 36,
   parameter int SHIFT  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp_valid,
   input  logic [PIX_W-1:0] smp,
   output logic [PIX_W-1:0] avg,
   output logic             full
);
   localparam int CNT_W = $clog2(DARK_N + 1);
   localparam int SUM_W = PIX_W + $clog2(DARK_N) + 1;

   initial begin : p_param_chk
      assert (DARK_N == 4 + (1 << SHIFT)) else $error("DARK_N must be 4 + 2**SHIFT");
      assert (PIX_W >= 2) else $error("PIX_W too small");
   end

   logic [CNT_W-1:0] cnt;
   logic [SUM_W-1:0] sum;
   logic [PIX_W-1:0] lo1, lo2, hi1, hi2;
   logic [SUM_W-1:0] trim_full;
   logic             take;

   assign full = (cnt == CNT_W'(DARK_N));
   assign take = smp_valid && !full && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         sum <= '0;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         sum <= sum + SUM_W'(smp);
      end
   end

   rnc_extreme_pair #(.W(PIX_W), .KEEP_HIGH(1'b0)) u_low (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(take), .x(smp), .e1(lo1), .e2(lo2));

   rnc_extreme_pair #(.W(PIX_W), .KEEP_HIGH(1'b1)) u_high (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(take), .x(smp), .e1(hi1), .e2(hi2));

   assign trim_full = sum - SUM_W'(lo1) - SUM_W'(lo2) - SUM_W'(hi1) - SUM_W'(hi2);
   assign avg       = PIX_W'(trim_full >> SHIFT);

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(DARK_N))
      else $error("dark sample count overran");

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> cnt == '0)
      else $error("statistics not cleared between rows");
endmodule

// File: rtl/rnc_apply.sv
module rnc_apply #(
   parameter int PIX_W = 10,
   parameter int PED_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_line,
   input  logic             in_dark,
   input  logic [PIX_W-1:0] in_pix,
   input  logic [PIX_W-1:0] avg,
   input  logic             corr_on,
   input  logic [PED_W-1:0] ped,
   output logic             out_valid,
   output logic             out_line,
   output logic [PIX_W-1:0] out_pix
);
   import rnc_pkg::*;

   localparam int EW = PIX_W + 3;
   localparam logic signed [EW-1:0] MAXV = $signed({3'b000, {PIX_W{1'b1}}});

   initial begin : p_param_chk
      assert (PED_W <= PIX_W) else $error("pedestal wider than pixel");
   end

   pix_kind_e               kind;
   logic signed [EW-1:0]    diff;
   logic        [PIX_W-1:0] clamped;
   logic        [PIX_W-1:0] nxt;

   assign kind = classify(in_valid, in_line, in_dark);
   assign diff = $signed({3'b000, in_pix}) - $signed({3'b000, avg})
               + $signed({{(EW-PED_W){1'b0}}, ped});

   always_comb begin
      if (diff[EW-1])      clamped = '0;
      else if (diff > MAXV) clamped = '1;
      else                 clamped = diff[PIX_W-1:0];
   end

   always_comb begin
      unique case (kind)
         PK_ACTIVE: nxt = corr_on ? clamped : in_pix;
         PK_DARK:   nxt = in_pix;
         default:   nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_line  <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid && in_line;
         out_line  <= in_line;
         out_pix   <= nxt;
      end
   end

   // R3 R8
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_line && (in_dark || !corr_on)) |=> out_pix == $past(in_pix))
      else $error("uncorrected sample altered");

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> out_pix == '0)
      else $error("output pixel not zero while idle");
endmodule

// File: rtl/rownoise_canceller.sv
module rownoise_canceller #(
   parameter int PIX_W  = 10,
   parameter int PED_W  = 8,
   parameter int DARK_N = 36,
   parameter int SHIFT  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_line,
   input  logic             in_dark,
   input  logic [PIX_W-1:0] in_pix,
   input  logic             cfg_dark_read_en,
   input  logic             cfg_corr_en,
   input  logic [PED_W-1:0] cfg_pedestal,
   output logic             out_valid,
   output logic             out_line,
   output logic [PIX_W-1:0] out_pix
);
   logic [PIX_W-1:0] row_ref;
   logic             ref_ready;
   logic             corr_on;
   logic             dark_smp;

   assign corr_on  = cfg_dark_read_en && cfg_corr_en;
   assign dark_smp = in_valid && in_line && in_dark;

   rnc_dark_stats #(.PIX_W(PIX_W), .DARK_N(DARK_N), .SHIFT(SHIFT)) u_stats (
      .clk(clk), .rst_n(rst_n), .clr(!in_line), .smp_valid(dark_smp), .smp(in_pix),
      .avg(row_ref), .full(ref_ready));

   rnc_apply #(.PIX_W(PIX_W), .PED_W(PED_W)) u_apply (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line), .in_dark(in_dark),
      .in_pix(in_pix), .avg(row_ref), .corr_on(corr_on), .ped(cfg_pedestal),
      .out_valid(out_valid), .out_line(out_line), .out_pix(out_pix));

   // R4: input assumption, the dark run is complete before correction is applied
   ref_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_line && !in_dark && corr_on) |-> ref_ready)
      else $error("active pixel before full dark run");

   // R2
   line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_line) |=> $rose(out_line))
      else $error("line framing not forwarded");
endmodule

// File: tb/rownoise_canceller_bench.sv
module rownoise_canceller_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_line, in_dark;
   logic [9:0] in_pix;
   logic       cfg_dark_read_en, cfg_corr_en;
   logic [7:0] cfg_pedestal;
   logic       out_valid, out_line;
   logic [9:0] out_pix;

   int    vectors = 0;
   int    misses  = 0;
   logic  exp_v, exp_l;
   logic [9:0] exp_p;
   string exp_tag;
   int    dq[$];

   always #5 clk = ~clk;

   rownoise_canceller u_rownoise_canceller (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line), .in_dark(in_dark),
      .in_pix(in_pix), .cfg_dark_read_en(cfg_dark_read_en), .cfg_corr_en(cfg_corr_en),
      .cfg_pedestal(cfg_pedestal), .out_valid(out_valid), .out_line(out_line), .out_pix(out_pix));

   function automatic int trimmed_ref(input int q[$]);
      int s[$];
      int acc = 0;
      s = q;
      s.sort();
      for (int i = 2; i < s.size() - 2; i++) acc += s[i];
      return acc >> 5;
   endfunction

   task automatic compare();
      vectors++;
      if (out_valid !== exp_v || out_line !== exp_l || out_pix !== exp_p) begin
         misses++;
         $display("FAIL %s: got v=%0b l=%0b pix=%0d, expected v=%0b l=%0b pix=%0d",
                  exp_tag, out_valid, out_line, out_pix, exp_v, exp_l, exp_p);
      end
   endtask

   task automatic step(input bit v, input bit l, input bit d, input int p);
      int r;
      @(negedge clk);
      compare();
      in_valid = v; in_line = l; in_dark = d; in_pix = 10'(p);
      if (!l) dq.delete();
      exp_v = v && l;
      exp_l = l;
      if (v && l && d) begin
         if (dq.size() < 36) dq.push_back(p);
         exp_p = 10'(p); exp_tag = "R3";
      end else if (v && l) begin
         if (cfg_corr_en && cfg_dark_read_en) begin
            r = p - trimmed_ref(dq) + int'(cfg_pedestal);
            if (r < 0)         begin exp_p = 10'd0;    exp_tag = "R6"; end
            else if (r > 1023) begin exp_p = 10'd1023; exp_tag = "R7"; end
            else               begin exp_p = 10'(r);   exp_tag = "R5"; end
         end else begin
            exp_p = 10'(p); exp_tag = "R8";
         end
      end else begin
         exp_p = 10'd0; exp_tag = "R2";
      end
   endtask

   task automatic send_row(input int dk[$], input int ac[$]);
      foreach (dk[i]) step(1, 1, 1, dk[i]);
      foreach (ac[i]) begin
         step(1, 1, 0, ac[i]);
         if (i % 5 == 4) step(0, 1, 0, 0);
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
   endtask

   function automatic void fill(ref int q[$], input int val);
      q.delete();
      for (int i = 0; i < 36; i++) q.push_back(val);
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      misses++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin : main
      int dk[$];
      int ac[$];
      rst_n = 1'b0;
      in_valid = 0; in_line = 0; in_dark = 0; in_pix = '0;
      cfg_dark_read_en = 1; cfg_corr_en = 1; cfg_pedestal = 8'd20;
      // R1: outputs held at zero through reset
      repeat (3) begin
         @(negedge clk);
         exp_v = 0; exp_l = 0; exp_p = 0; exp_tag = "R1";
         compare();
      end
      rst_n = 1'b1;
      exp_v = 0; exp_l = 0; exp_p = 0; exp_tag = "R1";
      step(0, 0, 0, 0);

      // R4 R5: spread dark levels with outliers at both ends
      dk.delete();
      for (int i = 0; i < 36; i++) begin
         if (i == 2)       dk.push_back(1023);
         else if (i == 9)  dk.push_back(0);
         else if (i == 20) dk.push_back(1000);
         else if (i == 33) dk.push_back(3);
         else              dk.push_back(40 + (i * 7) % 13);
      end
      ac.delete();
      for (int i = 0; i < 16; i++) ac.push_back((i * 61 + 50) % 1024);
      send_row(dk, ac);

      // R10: triplicated extremes, reference expected 88
      fill(dk, 64);
      dk[1] = 5; dk[4] = 5; dk[7] = 5; dk[10] = 900; dk[20] = 900; dk[30] = 900;
      ac.delete();
      for (int i = 0; i < 8; i++) ac.push_back(100 + i * 3);
      send_row(dk, ac);

      // R6: low clamp
      cfg_pedestal = 8'd0;
      fill(dk, 500);
      ac = '{0, 100, 499, 500, 520, 1023};
      send_row(dk, ac);

      // R7: high clamp
      cfg_pedestal = 8'd255;
      fill(dk, 0);
      ac = '{1020, 900, 768, 767, 769, 1023};
      send_row(dk, ac);

      // R9: consecutive rows with very different dark levels
      cfg_pedestal = 8'd20;
      fill(dk, 300);
      ac = '{310, 400, 290, 1000};
      send_row(dk, ac);
      fill(dk, 10);
      ac = '{5, 400, 290, 1000};
      send_row(dk, ac);

      // R8: correction enable off, then dark read enable off
      cfg_corr_en = 0;
      fill(dk, 200);
      ac = '{0, 150, 777, 1023};
      send_row(dk, ac);
      cfg_corr_en = 1; cfg_dark_read_en = 0;
      send_row(dk, ac);
      cfg_dark_read_en = 1;
      step(0, 0, 0, 0);
      @(negedge clk);
      compare();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule